// File: doc/BRIEF.md
# Byte-Stream Wishbone Bus Master

This block sits behind a byte-wide receive stream, for example the receiver of a serial port, and turns framed commands into 32-bit classic Wishbone master cycles. A frame opens with a command byte that selects the direction and the address mode. A count byte follows and gives the number of words to move. Next come the address bytes, most significant first. For a write, the data words follow, each most significant byte first. The address carried in the frame is a word address.

A write gathers each data word from the stream and then runs one bus cycle with every byte lane enabled. A read runs one bus cycle per word and returns the word on a byte-wide output stream, most significant byte first. The next cycle does not start until the last of those bytes has been taken. In incrementing mode the address grows by one after each word. In fixed mode every word uses the same address, which suits a FIFO or data register. Once the requested number of words has been moved, the block waits for the next command byte.

Top module: `sbw_bridge`

## Requirements
- R1: Only the command bytes 0x01, 0x02, 0x03 and 0x04 open a frame. Any other byte received while waiting for a command is consumed and dropped, and it starts no bus cycle.
- R2: After the command byte comes one count byte, then four address bytes, most significant first. The assembled value drives wb_adr_o unchanged as a word address for the first word.
- R3: Command 0x01 (incrementing write) takes four data bytes per word, most significant first. It issues one write cycle per word with wb_we_o=1 and wb_sel_o=4'b1111, and the address grows by one per word.
- R4: Command 0x03 (fixed write) behaves like R3, except that every word is written to the address received in the frame.
- R5: Command 0x02 (incrementing read) issues one read cycle per word with the address growing by one. It sends the four bytes of each returned word, most significant first, on out_data.
- R6: Command 0x04 (fixed read) behaves like R5, except that every word is read from the address received in the frame.
- R7: A bus cycle holds wb_cyc_o, wb_stb_o, wb_adr_o, wb_we_o and wb_dat_o steady until wb_ack_i. While wb_cyc_o is high, in_ready is low and no input byte is taken.
- R8: While out_valid is high and out_ready is low, out_valid and out_data stay unchanged. No read data is offered while a bus cycle is open, and the next read cycle starts only after all four bytes of the current word have been taken.
- R9: A count byte of zero ends the frame after the address bytes without any bus cycle.
- R10: After the counted number of words, or after reset, the block takes the next input byte as a command byte.
- R11: Each bus cycle lasts until its acknowledge and then ends. wb_stb_o equals wb_cyc_o at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block takes the input byte this cycle |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Read data byte present |
| out_ready | input | 1 | Receiver takes the output byte |
| out_data | output | 8 | Read data byte |
| wb_cyc_o | output | 1 | Bus cycle in progress |
| wb_stb_o | output | 1 | Bus strobe |
| wb_we_o | output | 1 | Write enable |
| wb_adr_o | output | 32 | Word address |
| wb_sel_o | output | 4 | Byte lane selects |
| wb_dat_o | output | 32 | Write data |
| wb_dat_i | input | 32 | Read data |
| wb_ack_i | input | 1 | Cycle acknowledge |

## Verification
The bench runs each of the four commands and feeds them distinct byte patterns. Incrementing writes show whether the address grows and whether bytes are packed most significant first. Fixed writes under a slow acknowledge show whether the address is held and whether input is stalled during the cycle. Reads return a word derived from the address, so both the mode and the byte order of the returned stream can be seen. The reads run under an irregular out_ready pattern to test holding of the output. Illegal command bytes and zero-count frames are each followed by a normal frame, which shows that the stray bytes were dropped and that the block went back to waiting for a command.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
   localparam logic [7:0] CMD_WR_INC = 8'h01;
   localparam logic [7:0] CMD_RD_INC = 8'h02;
   localparam logic [7:0] CMD_WR_FIX = 8'h03;
   localparam logic [7:0] CMD_RD_FIX = 8'h04;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEN,
      ST_ADDR,
      ST_WDATA,
      ST_WBUS,
      ST_RBUS,
      ST_RSEND
   } sbw_state_e;
endpackage

// File: rtl/sbw_byte_packer.sv
module sbw_byte_packer #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         take,
   input  logic [7:0]   byte_i,
   output logic [W-1:0] word_o,
   output logic         last_o
);
   localparam int NB = W / 8;

   generate
      if (NB == 1) begin : g_single
         assign word_o = byte_i;
         assign last_o = 1'b1;
      end else begin : g_multi
         localparam int CW = $clog2(NB);
         logic [W-9:0]  held;
         logic [CW-1:0] cnt;

         assign word_o = {held, byte_i};
         assign last_o = (cnt == CW'(NB - 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               held <= '0;
               cnt  <= '0;
            end else if (take) begin
               held <= word_o[W-9:0];
               cnt  <= cnt + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/sbw_byte_unpacker.sv
module sbw_byte_unpacker #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] word_i,
   input  logic         take,
   output logic [7:0]   byte_o,
   output logic         last_o
);
   localparam int NB = W / 8;

   generate
      if (NB == 1) begin : g_single
         logic [7:0] hold;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    hold <= '0;
            else if (load) hold <= word_i;
         end
         assign byte_o = hold;
         assign last_o = 1'b1;
      end else begin : g_multi
         localparam int CW = $clog2(NB);
         logic [W-1:0]  shreg;
         logic [CW-1:0] cnt;

         assign byte_o = shreg[W-1:W-8];
         assign last_o = (cnt == CW'(NB - 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               shreg <= '0;
               cnt   <= '0;
            end else if (load) begin
               shreg <= word_i;
               cnt   <= '0;
            end else if (take) begin
               shreg <= {shreg[W-9:0], 8'h00};
               cnt   <= cnt + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/sbw_addr_step.sv
module sbw_addr_step #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          step,
   input  logic          incr,
   output logic [AW-1:0] addr_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            addr_o <= '0;
      else if (load)         addr_o <= load_val;
      else if (step && incr) addr_o <= addr_o + 1'b1;
   end
endmodule

// File: rtl/sbw_bridge.sv
module sbw_bridge #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [7:0]          in_data,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [7:0]          out_data,
   output logic                wb_cyc_o,
   output logic                wb_stb_o,
   output logic                wb_we_o,
   output logic [ADDR_W-1:0]   wb_adr_o,
   output logic [DATA_W/8-1:0] wb_sel_o,
   output logic [DATA_W-1:0]   wb_dat_o,
   input  logic [DATA_W-1:0]   wb_dat_i,
   input  logic                wb_ack_i
);
   import sbw_pkg::*;

   localparam int DBYTES = DATA_W / 8;
   localparam int ABYTES = ADDR_W / 8;
   localparam int LEN_W  = 8;

   generate
      if ((DATA_W % 8) != 0 || (DBYTES & (DBYTES - 1)) != 0) begin : g_bad_data
         $error("sbw_bridge: DATA_W must be a power-of-two number of bytes");
      end
      if ((ADDR_W % 8) != 0 || (ABYTES & (ABYTES - 1)) != 0) begin : g_bad_addr
         $error("sbw_bridge: ADDR_W must be a power-of-two number of bytes");
      end
   endgenerate

   sbw_state_e         state, state_nxt;
   logic               is_wr, is_inc;
   logic [LEN_W-1:0]   len_q, wcnt;
   logic [DATA_W-1:0]  wdata_q;
   logic               in_fire, out_fire, bus_ack;
   logic               cmd_ok, cmd_wr, cmd_inc;
   logic               a_take, a_last, d_take, d_last, u_last;
   logic [ADDR_W-1:0]  a_word;
   logic [DATA_W-1:0]  d_word;

   // full-value compare of each command code
   always_comb begin
      cmd_wr  = (in_data == CMD_WR_INC) || (in_data == CMD_WR_FIX);
      cmd_inc = (in_data == CMD_WR_INC) || (in_data == CMD_RD_INC);
      cmd_ok  = cmd_wr || (in_data == CMD_RD_INC) || (in_data == CMD_RD_FIX);
   end

   assign in_ready  = (state == ST_IDLE) || (state == ST_LEN) ||
                      (state == ST_ADDR) || (state == ST_WDATA);
   assign in_fire   = in_valid && in_ready;
   assign out_valid = (state == ST_RSEND);
   assign out_fire  = out_valid && out_ready;
   assign wb_cyc_o  = (state == ST_WBUS) || (state == ST_RBUS);
   assign wb_stb_o  = wb_cyc_o;
   assign wb_we_o   = (state == ST_WBUS);
   assign wb_sel_o  = '1;
   assign wb_dat_o  = wdata_q;
   assign bus_ack   = wb_cyc_o && wb_ack_i;
   assign a_take    = in_fire && (state == ST_ADDR);
   assign d_take    = in_fire && (state == ST_WDATA);

   sbw_byte_packer #(.W(ADDR_W)) u_addr_pack (
      .clk(clk), .rst_n(rst_n), .take(a_take), .byte_i(in_data),
      .word_o(a_word), .last_o(a_last)
   );

   sbw_byte_packer #(.W(DATA_W)) u_data_pack (
      .clk(clk), .rst_n(rst_n), .take(d_take), .byte_i(in_data),
      .word_o(d_word), .last_o(d_last)
   );

   sbw_byte_unpacker #(.W(DATA_W)) u_rd_unpack (
      .clk(clk), .rst_n(rst_n), .load(bus_ack && !wb_we_o), .word_i(wb_dat_i),
      .take(out_fire), .byte_o(out_data), .last_o(u_last)
   );

   sbw_addr_step #(.AW(ADDR_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .load(a_take && a_last), .load_val(a_word),
      .step(bus_ack), .incr(is_inc), .addr_o(wb_adr_o)
   );

   always_comb begin
      state_nxt = state;
      unique case (state)
         ST_IDLE:  if (in_fire && cmd_ok) state_nxt = ST_LEN;
         ST_LEN:   if (in_fire) state_nxt = ST_ADDR;
         ST_ADDR:  if (a_take && a_last) begin
                      if (len_q == '0) state_nxt = ST_IDLE;
                      else if (is_wr)  state_nxt = ST_WDATA;
                      else             state_nxt = ST_RBUS;
                   end
         ST_WDATA: if (d_take && d_last) state_nxt = ST_WBUS;
         ST_WBUS:  if (wb_ack_i)
                      state_nxt = ((wcnt + 1'b1) == len_q) ? ST_IDLE : ST_WDATA;
         ST_RBUS:  if (wb_ack_i) state_nxt = ST_RSEND;
         ST_RSEND: if (out_fire && u_last)
                      state_nxt = (wcnt == len_q) ? ST_IDLE : ST_RBUS;
         default:  state_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         is_wr   <= 1'b0;
         is_inc  <= 1'b0;
         len_q   <= '0;
         wcnt    <= '0;
         wdata_q <= '0;
      end else begin
         state <= state_nxt;
         if (state == ST_IDLE && in_fire && cmd_ok) begin
            is_wr  <= cmd_wr;
            is_inc <= cmd_inc;
         end
         if (state == ST_LEN && in_fire) begin
            len_q <= in_data;
            wcnt  <= '0;
         end
         if (bus_ack)           wcnt    <= wcnt + 1'b1;
         if (d_take && d_last)  wdata_q <= d_word;
      end
   end
endmodule

// File: rtl/sbw_bridge_chk.sv
module sbw_bridge_chk #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [7:0]        out_data,
   input logic              wb_cyc_o,
   input logic              wb_we_o,
   input logic [ADDR_W-1:0] wb_adr_o,
   input logic [DATA_W-1:0] wb_dat_o,
   input logic              wb_ack_i
);
   p_hold_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_cyc_o && !wb_ack_i) |=> (wb_cyc_o && $stable(wb_adr_o) &&
                                   $stable(wb_we_o) && $stable(wb_dat_o)));

   p_no_take_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wb_cyc_o |-> !in_ready);

   p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   p_no_out_in_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wb_cyc_o |-> !out_valid);

   p_end_on_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_cyc_o && wb_ack_i) |=> !wb_cyc_o);
endmodule

bind sbw_bridge sbw_bridge_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
   .out_ready(out_ready), .out_data(out_data), .wb_cyc_o(wb_cyc_o),
   .wb_we_o(wb_we_o), .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o),
   .wb_ack_i(wb_ack_i)
);

// File: tb/tb_sbw_bridge.sv
module tb_sbw_bridge;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [7:0]  in_data = 8'h00;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [7:0]  out_data;
   logic        wb_cyc_o, wb_stb_o, wb_we_o, wb_ack_i;
   logic [31:0] wb_adr_o, wb_dat_o, wb_dat_i;
   logic [3:0]  wb_sel_o;

   int checks = 0, errors = 0;
   int ack_delay = 0, waitc = 0;
   int wr_n = 0, rd_n = 0;
   logic [31:0] wr_adr [0:63];
   logic [31:0] wr_dat [0:63];
   logic [3:0]  wr_sel [0:63];
   logic [31:0] rd_adr [0:63];
   logic [7:0]  rx [0:63];
   int rx_n = 0;
   int bus_take_viol = 0, hold_viol = 0, stb_viol = 0;
   logic hold_prev = 1'b0;
   logic [7:0] prev_data = 8'h00;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   sbw_bridge dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o),
      .wb_we_o(wb_we_o), .wb_adr_o(wb_adr_o), .wb_sel_o(wb_sel_o),
      .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i), .wb_ack_i(wb_ack_i)
   );

   function automatic logic [31:0] rd_pat(input logic [31:0] a);
      return {a[7:0] ^ 8'hC3, a[15:8], 8'h5A, a[7:0] + 8'h11};
   endfunction

   // bus slave model with programmable acknowledge delay
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_ack_i <= 1'b0;
         wb_dat_i <= '0;
         waitc    <= 0;
      end else begin
         wb_ack_i <= 1'b0;
         if (wb_cyc_o && wb_stb_o && !wb_ack_i) begin
            if (waitc >= ack_delay) begin
               wb_ack_i <= 1'b1;
               waitc    <= 0;
               if (wb_we_o) begin
                  wr_adr[wr_n] <= wb_adr_o;
                  wr_dat[wr_n] <= wb_dat_o;
                  wr_sel[wr_n] <= wb_sel_o;
                  wr_n <= wr_n + 1;
               end else begin
                  rd_adr[rd_n] <= wb_adr_o;
                  wb_dat_i     <= rd_pat(wb_adr_o);
                  rd_n <= rd_n + 1;
               end
            end else begin
               waitc <= waitc + 1;
            end
         end
      end
   end

   // handshake monitors, sampled before the edge updates the design
   always @(posedge clk) begin
      if (rst_n) begin
         if (wb_cyc_o && in_ready) bus_take_viol++;
         if (wb_cyc_o != wb_stb_o) stb_viol++;
         if (hold_prev && !(out_valid && out_data == prev_data)) hold_viol++;
         hold_prev <= out_valid && !out_ready;
         prev_data <= out_data;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send_byte(input logic [7:0] b);
      in_valid = 1'b1;
      in_data  = b;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic send_hdr(input logic [7:0] cmd, input logic [7:0] len,
                           input logic [31:0] a);
      send_byte(cmd);
      send_byte(len);
      for (int i = 3; i >= 0; i--) send_byte(a[8*i +: 8]);
   endtask

   task automatic send_word(input logic [31:0] w);
      for (int i = 3; i >= 0; i--) send_byte(w[8*i +: 8]);
   endtask

   task automatic recv_bytes(input int n);
      int k = 0;
      rx_n = 0;
      while (rx_n < n && k < 4000) begin
         out_ready = (k % 3) != 1;
         if (out_valid && out_ready) begin
            rx[rx_n] = out_data;
            rx_n++;
         end
         k++;
         @(negedge clk);
      end
      out_ready = 1'b0;
   endtask

   task automatic idle_wait;
      repeat (8) @(negedge clk);
   endtask

   task automatic t_reset;
      chk(in_ready === 1'b1, "R10 reset in_ready", {31'b0, in_ready}, 32'd1);
      chk(out_valid === 1'b0, "R10 reset out_valid", {31'b0, out_valid}, 32'd0);
      chk(wb_cyc_o === 1'b0, "R11 reset cyc", {31'b0, wb_cyc_o}, 32'd0);
   endtask

   task automatic t_write_inc;
      int base = wr_n;
      logic [31:0] d [0:2];
      d[0] = 32'h11223344; d[1] = 32'hA0B0C0D0; d[2] = 32'h0F1E2D3C;
      ack_delay = 0;
      send_hdr(8'h01, 8'd3, 32'h0000_0010);
      for (int i = 0; i < 3; i++) send_word(d[i]);
      idle_wait();
      chk(wr_n - base == 3, "R3 write count", wr_n - base, 3);
      for (int i = 0; i < 3; i++) begin
         chk(wr_adr[base+i] == 32'h10 + i, "R2 R3 incr address", wr_adr[base+i], 32'h10 + i);
         chk(wr_dat[base+i] == d[i], "R3 write data order", wr_dat[base+i], d[i]);
         chk(wr_sel[base+i] == 4'hF, "R3 byte selects", {28'b0, wr_sel[base+i]}, 32'hF);
      end
   endtask

   task automatic t_write_fix;
      int base = wr_n;
      ack_delay = 3;
      send_hdr(8'h03, 8'd2, 32'h1234_5678);
      send_word(32'hDEADBEEF);
      send_word(32'hCAFEF00D);
      idle_wait();
      ack_delay = 0;
      chk(wr_n - base == 2, "R4 write count", wr_n - base, 2);
      chk(wr_adr[base] == 32'h12345678, "R2 R4 fixed address", wr_adr[base], 32'h12345678);
      chk(wr_adr[base+1] == 32'h12345678, "R4 fixed address", wr_adr[base+1], 32'h12345678);
      chk(wr_dat[base+1] == 32'hCAFEF00D, "R4 R7 data under slow ack", wr_dat[base+1], 32'hCAFEF00D);
   endtask

   task automatic t_read(input logic [7:0] cmd, input logic [31:0] a, input int n,
                         input bit inc, input string req);
      int base = rd_n;
      logic [31:0] ea, w;
      send_hdr(cmd, n[7:0], a);
      recv_bytes(4 * n);
      idle_wait();
      chk(rd_n - base == n, {req, " read count"}, rd_n - base, n);
      chk(rx_n == 4 * n, {req, " byte count"}, rx_n, 4 * n);
      for (int i = 0; i < n; i++) begin
         ea = inc ? a + i : a;
         chk(rd_adr[base+i] == ea, {req, " read address"}, rd_adr[base+i], ea);
         w = {rx[4*i], rx[4*i+1], rx[4*i+2], rx[4*i+3]};
         chk(w == rd_pat(ea), {req, " R8 bytes msb first"}, w, rd_pat(ea));
      end
   endtask

   task automatic t_bad_cmd;
      int base = wr_n;
      int rbase = rd_n;
      send_byte(8'h00);
      send_byte(8'h05);
      send_byte(8'hFF);
      idle_wait();
      chk(wr_n == base && rd_n == rbase, "R1 no cycle on bad code", wr_n - base, 0);
      send_hdr(8'h01, 8'd1, 32'h0000_0003);
      send_word(32'h55667788);
      idle_wait();
      chk(wr_n - base == 1, "R1 frame after dropped bytes", wr_n - base, 1);
      chk(wr_adr[base] == 32'h3, "R1 address after drop", wr_adr[base], 32'h3);
      chk(wr_dat[base] == 32'h55667788, "R1 data after drop", wr_dat[base], 32'h55667788);
   endtask

   task automatic t_zero_len;
      int base = wr_n;
      int rbase = rd_n;
      send_hdr(8'h01, 8'd0, 32'h0000_000A);
      send_hdr(8'h02, 8'd0, 32'h0000_000B);
      idle_wait();
      chk(wr_n == base && rd_n == rbase, "R9 zero length no cycle", wr_n - base + rd_n - rbase, 0);
      chk(out_valid === 1'b0, "R9 zero length no output", {31'b0, out_valid}, 0);
      send_hdr(8'h03, 8'd1, 32'h0000_0005);
      send_word(32'h01020304);
      idle_wait();
      chk(wr_n - base == 1 && wr_adr[base] == 32'h5, "R10 next frame after zero length",
          wr_adr[base], 32'h5);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write_inc();
      t_write_fix();
      ack_delay = 0;
      t_read(8'h02, 32'h0000_0020, 3, 1'b1, "R5");
      ack_delay = 2;
      t_read(8'h04, 32'hABCD_0001, 2, 1'b0, "R6");
      ack_delay = 0;
      t_bad_cmd();
      t_zero_len();
      chk(bus_take_viol == 0, "R7 input taken during cycle", bus_take_viol, 0);
      chk(hold_viol == 0, "R8 output changed under backpressure", hold_viol, 0);
      chk(stb_viol == 0, "R11 stb differs from cyc", stb_viol, 0);
      if (!finished) begin
         finished = 1'b1;
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule